// File: doc/BRIEF.md
# Weighted Round-Robin Input Arbiter

This block picks one of several message inputs per clock and hands that choice to a single consumer. Each input presents a valid line, a message length and an interface enable. A per-input 3-bit weight code controls how many messages the input may send in a row once it holds the grant. When that quota is used up, or the holder stops presenting valid, the grant moves to the next eligible input in ascending index order, wrapping around. The consumer accepts a message by raising its ready line while the grant is valid. The selected input then receives a one-cycle acknowledge.

Alongside arbitration, the block keeps the length of the last accepted message for each input. It raises a sticky per-input flag when a newly accepted message carries a different length. The consumer side reads the flags through a read strobe, and that strobe clears them. The block produces only the grant index. Steering the payload is left to the surrounding logic.

Top module: `wrr_arbiter`

## Requirements
- R1: Weight code 0 grants a quota of 8 consecutive messages; codes 1 to 7 grant a quota equal to the code. The code of input i sits in bits [3i+2:3i] of the packed weight field.
- R2: While the grant holder stays valid and enabled and has accepted fewer messages than its quota in the current turn, the grant stays on it, including across cycles where the consumer is not ready.
- R3: When the holder has no quota left, the grant goes to the first eligible input found scanning upward from the holder's index plus one, wrapping. The holder itself is reached last and starts a fresh turn only if it is the sole eligible input.
- R4: If the holder drops valid (or is disabled) before its quota is spent, the grant moves in that same cycle to the next eligible input in the rotation.
- R5: An input whose enable is 0 is never granted and its acknowledge stays 0, whatever its valid shows.
- R6: An acknowledge is raised for exactly the granted input in a cycle where out_valid and out_ready are both 1, and for no input otherwise.
- R7: out_valid is 1 exactly when at least one input is both valid and enabled.
- R8: The quota of a turn is taken from the weight code at the moment the turn's first message is accepted. Later changes to that code apply from the next turn onward.
- R9: A cycle with out_ready low changes no turn count.
- R10: On an accepted message, the input's mismatch flag is set when the input has an earlier accepted message since reset and the new length differs from it. The first message after reset never sets the flag.
- R11: Mismatch flags stay set until a cycle with mis_read high clears all of them. A mismatch detected in that same cycle leaves its flag set.
- R12: After reset all flags are 0, no turn is open, and the rotation scan starts at input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_enable | input | N | Per-input interface enable |
| wt_code | input | 3*N | Packed weight codes, input 0 in the low bits |
| in_valid | input | N | Per-input message valid |
| in_len | input | LEN_W*N | Packed per-input message lengths |
| in_ack | output | N | Per-input acknowledge, one-hot or zero |
| out_valid | output | 1 | A grant is presented |
| out_idx | output | $clog2(N) | Index of the granted input |
| out_ready | input | 1 | Consumer accepts the granted message |
| mis_read | input | 1 | Read strobe that clears the mismatch flags |
| mis_flags | output | N | Sticky per-input length mismatch flags |

## Verification
The assertions check, in every cycle, the properties that need no memory of earlier turns. These are the one-hot acknowledge tied to the handshake, that a grant only lands on a valid and enabled input, that a grant is offered exactly when some input is eligible, that flags hold until read, and that a flag only rises after that input was acknowledged. Quota counting, turn order under rotation, quota latching at the start of a turn and the exact length comparison depend on history. Only the bench's reference model can show these, by tracking turns and lengths cycle by cycle under directed and pseudo-random traffic with changing weights, enables and ready.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CODE_W  = 3;
    localparam int COUNT_W = 4;

    typedef logic [CODE_W-1:0]  wcode_t;
    typedef logic [COUNT_W-1:0] wcount_t;

    // Code 0 is the largest share (8); other codes stand for themselves.
    function automatic wcount_t code_to_quota(input wcode_t code);
        wcount_t q;
        if (code == '0) q = wcount_t'(8);
        else            q = wcount_t'(code);
        return q;
    endfunction
endpackage

// File: rtl/wrr_pick.sv
module wrr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     elig,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    timeunit 1ns;
    timeprecision 1ps;

    // Rotating first-one search beginning at 'start', wrapping at N.
    always_comb begin
        int c;
        found = 1'b0;
        idx   = '0;
        c     = 0;
        for (int k = 0; k < N; k++) begin
            c = int'(start) + k;
            if (c >= N) c = c - N;
            if (!found && elig[c]) begin
                found = 1'b1;
                idx   = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/wrr_turn.sv
module wrr_turn
    import wrr_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       elig,
    input  logic [CODE_W*N-1:0] wt_code,
    input  logic               out_ready,
    input  logic               pick_found,
    input  logic [IDX_W-1:0]   pick_idx,
    output logic [IDX_W-1:0]   scan_start,
    output logic               grant_valid,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               accept
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    typedef struct packed {
        logic             live;
        logic [IDX_W-1:0] cur;
        wcount_t          used;
        wcount_t          quota;
    } turn_t;

    turn_t st_q, st_d;
    wcode_t codes [N];
    logic   keep;

    for (genvar i = 0; i < N; i++) begin : g_codes
        assign codes[i] = wt_code[CODE_W*i +: CODE_W];
    end

    assign keep       = st_q.live && elig[st_q.cur] && (st_q.used < st_q.quota);
    assign scan_start = (st_q.cur == LAST_IDX) ? '0 : st_q.cur + 1'b1;

    always_comb begin
        if (keep) begin
            grant_valid = 1'b1;
            grant_idx   = st_q.cur;
        end else begin
            grant_valid = pick_found;
            grant_idx   = pick_idx;
        end
    end

    assign accept = grant_valid && out_ready;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            if (keep) begin
                st_d.used = st_q.used + 1'b1;
            end else begin
                st_d.live  = 1'b1;
                st_d.cur   = grant_idx;
                st_d.used  = wcount_t'(1);
                st_d.quota = code_to_quota(codes[grant_idx]);
            end
        end else if (!keep) begin
            st_d.live = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.live  <= 1'b0;
            st_q.cur   <= LAST_IDX;
            st_q.used  <= '0;
            st_q.quota <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wrr_len_track.sv
module wrr_len_track #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LEN_W-1:0] len,
    input  logic             rd_clr,
    output logic             flag
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [LEN_W-1:0] last_q;
    logic             seen_q;
    logic             flag_d;

    always_comb begin
        flag_d = rd_clr ? 1'b0 : flag;
        if (take && seen_q && (len != last_q)) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            seen_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            flag <= flag_d;
            if (take) begin
                last_q <= len;
                seen_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wrr_arbiter.sv
module wrr_arbiter
    import wrr_pkg::*;
#(
    parameter int N     = 8,
    parameter int LEN_W = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         in_enable,
    input  logic [CODE_W*N-1:0]  wt_code,
    input  logic [N-1:0]         in_valid,
    input  logic [LEN_W*N-1:0]   in_len,
    output logic [N-1:0]         in_ack,
    output logic                 out_valid,
    output logic [IDX_W-1:0]     out_idx,
    input  logic                 out_ready,
    input  logic                 mis_read,
    output logic [N-1:0]         mis_flags
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [N-1:0]     elig;
    logic [IDX_W-1:0] scan_start;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             accept;

    assign elig = in_valid & in_enable;

    wrr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .elig  (elig),
        .start (scan_start),
        .found (pick_found),
        .idx   (pick_idx)
    );

    wrr_turn #(.N(N), .IDX_W(IDX_W)) u_turn (
        .clk         (clk),
        .rst         (rst),
        .elig        (elig),
        .wt_code     (wt_code),
        .out_ready   (out_ready),
        .pick_found  (pick_found),
        .pick_idx    (pick_idx),
        .scan_start  (scan_start),
        .grant_valid (out_valid),
        .grant_idx   (out_idx),
        .accept      (accept)
    );

    for (genvar i = 0; i < N; i++) begin : g_port
        assign in_ack[i] = accept && (out_idx == IDX_W'(i));

        wrr_len_track #(.LEN_W(LEN_W)) u_len (
            .clk    (clk),
            .rst    (rst),
            .take   (in_ack[i]),
            .len    (in_len[LEN_W*i +: LEN_W]),
            .rd_clr (mis_read),
            .flag   (mis_flags[i])
        );
    end
endmodule

// File: rtl/wrr_arbiter_chk.sv
module wrr_arbiter_chk #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     in_enable,
    input logic [N-1:0]     in_valid,
    input logic [N-1:0]     in_ack,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_idx,
    input logic             out_ready,
    input logic             mis_read,
    input logic [N-1:0]     mis_flags
);
    timeunit 1ns;
    timeprecision 1ps;

    // R6: at most one acknowledge per cycle
    p_ack_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ack));

    // R6: an acknowledge appears exactly on a completed handshake
    p_ack_handshake_r6: assert property (@(posedge clk) disable iff (rst)
        (|in_ack) == (out_valid && out_ready));

    // R5: the grant only lands on a valid, enabled input
    p_grant_eligible_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_valid[out_idx] && in_enable[out_idx]));

    // R5: no acknowledge to a disabled input
    p_ack_enabled_r5: assert property (@(posedge clk) disable iff (rst)
        (in_ack & ~in_enable) == '0);

    // R7: grant offered exactly when someone is eligible
    p_busy_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid == (|(in_valid & in_enable)));

    // R11: flags hold unless read
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !mis_read |=> ((mis_flags & $past(mis_flags)) == $past(mis_flags)));

    // R10: a flag only rises after that input was acknowledged
    p_flag_cause_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((mis_flags & ~$past(mis_flags) & ~$past(in_ack)) == '0));
endmodule

bind wrr_arbiter wrr_arbiter_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_enable (in_enable),
    .in_valid  (in_valid),
    .in_ack    (in_ack),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_ready (out_ready),
    .mis_read  (mis_read),
    .mis_flags (mis_flags)
);

// File: tb/wrr_arbiter_tb.sv
module wrr_arbiter_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 8;
    localparam int LW = 6;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    en = '0;
    logic [3*N-1:0]  wc = '0;
    logic [N-1:0]    valid = '0;
    logic [LW*N-1:0] lens = '0;
    logic [N-1:0]    ack;
    logic            ov;
    logic [IW-1:0]   oidx;
    logic            rdy = 1'b0;
    logic            mrd = 1'b0;
    logic [N-1:0]    flags;

    int checks = 0;
    int errors = 0;

    // reference model state
    int         m_cur;
    int         m_used;
    int         m_quota;
    bit         m_live;
    int         m_last [N];
    bit         m_seen [N];
    bit [N-1:0] m_flags;

    int obs_v;
    int obs_idx;
    bit [31:0] seed = 32'h1234_5679;

    always #2.5 clk = ~clk;

    wrr_arbiter #(.N(N), .LEN_W(LW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_enable (en),
        .wt_code   (wc),
        .in_valid  (valid),
        .in_len    (lens),
        .in_ack    (ack),
        .out_valid (ov),
        .out_idx   (oidx),
        .out_ready (rdy),
        .mis_read  (mrd),
        .mis_flags (flags)
    );

    function automatic bit [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cur = N - 1; m_used = 0; m_quota = 0; m_live = 0; m_flags = '0;
        for (int i = 0; i < N; i++) begin m_last[i] = 0; m_seen[i] = 0; end
    endtask

    task automatic do_reset();
        rst = 1'b1; valid = '0; rdy = 1'b0; mrd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // Called just after a falling edge with inputs applied; compares and
    // advances the model across the next rising edge.
    task automatic cycle();
        bit gv; int g; bit keep; bit acc; int w; int ln;
        logic [N-1:0] el; logic [N-1:0] eack; bit [N-1:0] nf;
        #1;
        el = valid & en;
        keep = m_live && el[m_cur] && (m_used < m_quota);
        gv = 0; g = 0;
        if (keep) begin gv = 1; g = m_cur; end
        else begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (m_cur + k) % N;
                if (!gv && el[c]) begin gv = 1; g = c; end
            end
        end
        acc = gv && rdy;
        eack = '0;
        if (acc) eack[g] = 1'b1;

        check(ov == gv, "R7 out_valid", int'(ov), int'(gv));
        if (gv) check(int'(oidx) == g, "R2 R3 R4 R8 R9 grant index", int'(oidx), g);
        check(ack == eack, "R5 R6 ack", int'(ack), int'(eack));
        check(flags == m_flags, "R10 R11 flags", int'(flags), int'(m_flags));
        obs_v = int'(ov); obs_idx = int'(oidx);

        nf = mrd ? '0 : m_flags;
        if (acc) begin
            ln = int'(lens[LW*g +: LW]);
            if (m_seen[g] && ln != m_last[g]) nf[g] = 1'b1;
            m_last[g] = ln; m_seen[g] = 1'b1;
            if (keep) m_used = m_used + 1;
            else begin
                w = int'(wc[3*g +: 3]);
                m_quota = (w == 0) ? 8 : w;   // R1 decode
                m_cur = g; m_used = 1; m_live = 1;
            end
        end else if (!keep) m_live = 0;
        @(posedge clk);
        m_flags = nf;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int seq [16];
        bit [31:0] r;
        @(negedge clk);
        do_reset();

        // R12: reset state with nothing requested
        en = '1; valid = '0; rdy = 1'b1;
        #1;
        check(ov == 1'b0 && ack == '0, "R12 idle after reset", int'(ov), 0);
        check(flags == '0, "R12 flags after reset", int'(flags), 0);
        @(negedge clk);
        cycle();

        // R1/R2/R3: all requesting, codes i0=0, i1=1, i2=2, others 3
        do_reset();
        en = '1; rdy = 1'b1; valid = '1;
        wc = {3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd2, 3'd1, 3'd0};
        for (int i = 0; i < N; i++) lens[LW*i +: LW] = LW'(5);
        for (int t = 0; t < 16; t++) begin
            cycle();
            seq[t] = obs_idx;
        end
        begin
            int run0;
            run0 = 0;
            for (int t = 0; t < 16; t++) if (seq[t] == 0 && run0 == t) run0++;
            check(run0 == 8, "R1 code 0 gives 8 in a row (R12 start at 0)", run0, 8);
        end
        check(seq[8] == 1, "R3 rotation to next input", seq[8], 1);
        check(seq[9] == 2 && seq[10] == 2, "R2 quota of 2 served", seq[10], 2);
        check(seq[11] == 3, "R3 rotation after quota", seq[11], 3);

        // R4: holder drops valid mid-turn
        valid = 8'b0010_1000;
        cycle(); cycle();
        valid = 8'b0010_0000;
        #1;
        check(ov && oidx == IW'(5), "R4 immediate move", int'(oidx), 5);
        @(negedge clk);
        cycle();

        // R5: disabled input with valid high
        valid = 8'b0000_0100; en = 8'b1111_1011;
        #1;
        check(!ov && ack == '0, "R5 disabled ignored", int'(ack), 0);
        @(negedge clk);
        cycle();
        en = '1;

        // R10/R11: length change then read
        valid = 8'b0000_0001; wc[2:0] = 3'd0;
        lens[LW-1:0] = LW'(7); cycle();
        lens[LW-1:0] = LW'(9); cycle();
        valid = '0; cycle();
        check(flags[0] == 1'b1, "R10 mismatch raised", int'(flags), 1);
        mrd = 1'b1; cycle(); mrd = 1'b0;
        check(flags[0] == 1'b0, "R11 cleared by read", int'(flags), 0);

        // Pseudo-random traffic compared against the model every cycle
        for (int t = 0; t < 3000; t++) begin
            r = rnd();
            if (r[0]) valid = r[15:8] | r[23:16];
            r = rnd();
            en = ~(r[7:0] & r[15:8] & r[23:16]);
            r = rnd();
            if (r[3:0] == 4'd0) wc = r[31:8];
            r = rnd();
            for (int i = 0; i < N; i++)
                lens[LW*i +: LW] = (r[i] && r[i+8] && r[i+16]) ? LW'(9) : LW'(5);
            r = rnd();
            rdy = (r[1:0] != 2'd0);
            mrd = (r[5:2] == 4'd0);
            cycle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule